// File: doc/BRIEF.md
# Decimal Sign-Format Converter

This block rewrites a fixed-point decimal operand from one sign convention to the other while the operand streams through it, one character per clock. Each character is seven bits: two zone bits, a four-bit BCD digit and an odd-parity bit. A memory-side operand keeps its sign in the upper zone bit of its lowest digit and stores the magnitude. An accumulator-side operand is in ten's complement, with its sign in the upper zone bit of its highest digit. Moving an operand into or out of an accumulator therefore needs this conversion on every transfer, and the block does it in a single pass with no storage for the operand.

A transfer begins with a one-cycle start strobe. The strobe carries the digit count, the direction and, when the source is an accumulator, the sign taken from the separate accumulator sign input. Characters then arrive lowest digit first with a valid strobe, and each one comes out converted one clock later with fresh parity. Input characters with bad parity set a sticky error flag but do not stop the transfer. A single-cycle done pulse marks the end of the transfer.

Top module: `dec_sign_conv`

## Requirements
- R1: Every output character is laid out as bit 6 = upper zone (sign carrier), bit 5 = lower zone, bits 4..1 = BCD digit (bit 4 most significant), bit 0 = parity, and the XOR of all seven output bits is 1.
- R2: With dir_i = 0 (memory to accumulator) and bit 6 of the first character = 0, each digit and each bit 5 pass through unchanged, and bit 6 is 0 on every output character. Bit 6 of characters other than the first has no effect.
- R3: With dir_i = 0 and bit 6 of the first character = 1, the output digits are the ten's complement of the magnitude, and bit 6 of the last output character is 1.
- R4: With dir_i = 0, a negative sign and an all-zero magnitude, every output digit is 0 and bit 6 of every output character is 0.
- R5: With dir_i = 1 (accumulator to memory), the sign comes from acc_sign_i sampled at start. When the sign is 1, the digits are complemented back to a magnitude. Bit 6 of the first output character equals the sign, and bit 6 of every other output character is 0. Bit 6 of the input characters has no effect.
- R6: Operand lengths of 1 and of MAX_DIGITS (100) convert correctly, including a one-digit negative operand whose sign moves within the same character.
- R7: An input character whose seven bits have even parity sets parity_err_o. The flag stays set until the next start, the conversion still completes, and the output characters carry correct parity.
- R8: Each accepted character appears on char_o with char_valid_o exactly one cycle after it is accepted. busy_o falls in the cycle after the last character is accepted. done_o is a one-cycle pulse in the cycle after the last output character.
- R9: After reset, and while no transfer is active, characters on the input produce no output and no done pulse.
- R10: A start strobe during a transfer abandons that transfer without a done pulse and begins the new one. When start and a character arrive in the same cycle, the character is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begins a transfer |
| len_i | input | LEN_W (7) | Digit count, 1..MAX_DIGITS, sampled at start |
| dir_i | input | 1 | 0: magnitude form to ten's complement; 1: reverse |
| acc_sign_i | input | 1 | Accumulator sign, sampled at start when dir_i = 1 |
| char_valid_i | input | 1 | Input character valid |
| char_i | input | 7 | Input character, lowest digit first |
| char_valid_o | output | 1 | Output character valid |
| char_o | output | 7 | Converted character |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| parity_err_o | output | 1 | Sticky input parity error |

## Verification
Positive operands in the forward direction show that digits and zone bits pass through untouched. Negative operands with trailing low zeros show whether the borrow point is found: zeros stay zero, the first nonzero digit becomes ten minus itself, and the rest become nine minus themselves. A negative zero separates "sign forced off for a zero magnitude" from plain sign copying. The reverse direction, run with both signs and with junk placed in the input zone bits, shows that the sign comes from the sign input and not from the data. One-digit and hundred-digit operands, a bad-parity character, an aborted transfer and characters sent while idle exercise the edges of the sequencing.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    // Seven-bit decimal character, most significant bit first
    typedef struct packed {
        logic       zx;   // upper zone, sign carrier
        logic       zo;   // lower zone
        logic [3:0] val;  // BCD digit
        logic       par;  // odd parity
    } dchar_t;

    typedef enum logic {
        DIR_TO_ACC   = 1'b0,
        DIR_FROM_ACC = 1'b1
    } conv_dir_e;

endpackage

// File: rtl/dsc_odd_par.sv
module dsc_odd_par #(
    parameter int PAY_W = 6
) (
    input  logic [PAY_W-1:0] payload_i,
    output logic             par_o
);
    // Parity bit that makes payload plus itself hold an odd number of ones
    assign par_o = ~(^payload_i);
endmodule

// File: rtl/dsc_digit_comp.sv
module dsc_digit_comp #(
    parameter int DIG_W = 4
) (
    input  logic [DIG_W-1:0] val_i,
    input  logic             negate_i,
    input  logic             seen_i,
    output logic [DIG_W-1:0] val_o,
    output logic             nz_o
);
    localparam logic [DIG_W-1:0] TEN  = DIG_W'(10);
    localparam logic [DIG_W-1:0] NINE = DIG_W'(9);

    always_comb begin
        nz_o = (val_i != '0);
        if (!negate_i) begin
            val_o = val_i;
        end else if (!seen_i) begin
            val_o = nz_o ? (TEN - val_i) : '0;
        end else begin
            val_o = NINE - val_i;
        end
    end

    always_comb begin
        if (val_i <= NINE) begin
            assert_digit_range_R3: assert (val_o <= NINE);
        end
    end
endmodule

// File: rtl/dec_sign_conv.sv
module dec_sign_conv
    import dsc_pkg::*;
#(
    parameter int MAX_DIGITS = 100,
    parameter int LEN_W      = $clog2(MAX_DIGITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             dir_i,
    input  logic             acc_sign_i,
    input  logic             char_valid_i,
    input  logic [6:0]       char_i,
    output logic             char_valid_o,
    output logic [6:0]       char_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             parity_err_o
);
    localparam int CHAR_W = $bits(dchar_t);
    localparam int PAY_W  = CHAR_W - 1;

    typedef struct packed {
        logic             active;
        logic [LEN_W-1:0] idx;
        logic [LEN_W-1:0] len;
        conv_dir_e        dir;
        logic             neg;
        logic             seen;
        logic             perr;
        logic             ovld;
        dchar_t           och;
        logic             last_out;
        logic             done;
    } state_t;

    state_t st_d, st_q;

    dchar_t           in_c;
    logic             accept;
    logic             first_c, last_c;
    logic             neg_now, seen_next;
    logic [3:0]       cval;
    logic             cnz;
    logic             x_out;
    logic [PAY_W-1:0] out_pay;
    logic             out_par;
    logic             in_par_exp;
    logic             in_bad;

    assign in_c    = dchar_t'(char_i);
    assign accept  = st_q.active & char_valid_i & ~start_i;
    assign first_c = (st_q.idx == '0);
    assign last_c  = (st_q.idx == LEN_W'(st_q.len - 1'b1));
    assign neg_now = (st_q.dir == DIR_TO_ACC && first_c) ? in_c.zx : st_q.neg;

    dsc_digit_comp #(.DIG_W(4)) u_comp (
        .val_i    (in_c.val),
        .negate_i (neg_now),
        .seen_i   (st_q.seen),
        .val_o    (cval),
        .nz_o     (cnz)
    );

    assign seen_next = st_q.seen | cnz;
    assign x_out = (st_q.dir == DIR_TO_ACC) ? (last_c & neg_now & seen_next)
                                            : (first_c & st_q.neg);
    assign out_pay = {x_out, in_c.zo, cval};

    dsc_odd_par #(.PAY_W(PAY_W)) u_par_out (
        .payload_i (out_pay),
        .par_o     (out_par)
    );

    dsc_odd_par #(.PAY_W(PAY_W)) u_par_in (
        .payload_i (char_i[CHAR_W-1:1]),
        .par_o     (in_par_exp)
    );

    assign in_bad = (in_par_exp != in_c.par);

    always_comb begin
        st_d          = st_q;
        st_d.ovld     = 1'b0;
        st_d.done     = st_q.last_out;
        st_d.last_out = 1'b0;
        if (start_i) begin
            st_d.active = 1'b1;
            st_d.idx    = '0;
            st_d.len    = len_i;
            st_d.dir    = conv_dir_e'(dir_i);
            st_d.neg    = (conv_dir_e'(dir_i) == DIR_FROM_ACC) ? acc_sign_i : 1'b0;
            st_d.seen   = 1'b0;
            st_d.perr   = 1'b0;
        end else if (accept) begin
            st_d.och  = dchar_t'({out_pay, out_par});
            st_d.ovld = 1'b1;
            st_d.idx  = st_q.idx + 1'b1;
            st_d.neg  = neg_now;
            st_d.seen = seen_next;
            st_d.perr = st_q.perr | in_bad;
            if (last_c) begin
                st_d.active   = 1'b0;
                st_d.last_out = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign char_valid_o = st_q.ovld;
    assign char_o       = st_q.och;
    assign busy_o       = st_q.active;
    assign done_o       = st_q.done;
    assign parity_err_o = st_q.perr;

    assert_out_odd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid_o |-> (^char_o));

    assert_sticky_perr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (parity_err_o && !start_i) |=> parity_err_o);

    assert_done_follows_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(char_valid_o));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_no_out_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid_o |-> $past(busy_o));
endmodule

// File: tb/dec_sign_conv_test.sv
`timescale 1ns/1ps
module dec_sign_conv_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [6:0] len_i = '0;
    logic       dir_i = 1'b0;
    logic       acc_sign_i = 1'b0;
    logic       char_valid_i = 1'b0;
    logic [6:0] char_i = '0;
    logic       char_valid_o, busy_o, done_o, parity_err_o;
    logic [6:0] char_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    int         in_dig [100];
    bit         in_o   [100];
    bit         in_x   [100];
    logic [6:0] exp_ch [100];
    logic [6:0] cap    [100];
    int         cap_n = 0;
    int         done_n = 0;

    always #2.5 clk = ~clk;

    dec_sign_conv uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
        .dir_i(dir_i), .acc_sign_i(acc_sign_i), .char_valid_i(char_valid_i),
        .char_i(char_i), .char_valid_o(char_valid_o), .char_o(char_o),
        .busy_o(busy_o), .done_o(done_o), .parity_err_o(parity_err_o)
    );

    always @(negedge clk) begin
        if (char_valid_o && cap_n < 100) begin
            cap[cap_n] = char_o;
            cap_n = cap_n + 1;
        end
        if (done_o) done_n = done_n + 1;
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    function automatic logic [6:0] mkc(input bit x, input bit o, input int d);
        logic [3:0] v;
        v = 4'(d);
        return {x, o, v, ~(x ^ o ^ v[3] ^ v[2] ^ v[1] ^ v[0])};
    endfunction

    // Drive one conversion and check it; tag names the requirement under test
    task automatic run_op(input bit dir, input bit sgn, input int n,
                          input int bad_idx, input string tag);
        int  borrow;
        bit  nz;
        int  outd [100];
        logic [6:0] c;
        nz = 0;
        for (int i = 0; i < n; i++) if (in_dig[i] != 0) nz = 1;
        borrow = 0;
        for (int i = 0; i < n; i++) begin
            if (sgn) begin
                int v;
                v = 0 - in_dig[i] - borrow;
                if (v < 0) begin v = v + 10; borrow = 1; end else borrow = 0;
                outd[i] = v;
            end else outd[i] = in_dig[i];
        end
        for (int i = 0; i < n; i++) begin
            bit xe;
            if (dir == 0) xe = (i == n - 1) ? (sgn && nz) : 1'b0;
            else          xe = (i == 0) ? sgn : 1'b0;
            exp_ch[i] = mkc(xe, in_o[i], outd[i]);
        end
        @(negedge clk);
        start_i = 1; len_i = 7'(n); dir_i = dir; acc_sign_i = (dir == 1) ? sgn : 1'b0;
        char_valid_i = 0;
        cap_n = 0; done_n = 0;
        @(negedge clk);
        start_i = 0;
        for (int i = 0; i < n; i++) begin
            bit xi;
            xi = (dir == 0 && i == 0) ? sgn : in_x[i];
            c = mkc(xi, in_o[i], in_dig[i]);
            if (i == bad_idx) c[0] = ~c[0];
            char_valid_i = 1; char_i = c;
            @(negedge clk);
        end
        char_valid_i = 0;
        chk(char_valid_o === 1'b1 && done_o === 1'b0, "R8", "last out timing",
            {char_valid_o, done_o}, 2'b10);
        chk(busy_o === 1'b0, "R8", "busy falls", busy_o, 0);
        @(negedge clk);
        chk(done_o === 1'b1 && char_valid_o === 1'b0, "R8", "done timing",
            {char_valid_o, done_o}, 2'b01);
        repeat (2) @(negedge clk);
        chk(cap_n == n, "R8", "output count", cap_n, n);
        chk(done_n == 1, "R8", "done pulses", done_n, 1);
        for (int i = 0; i < n && i < cap_n; i++) begin
            chk(cap[i] === exp_ch[i], tag, $sformatf("char %0d", i), cap[i], exp_ch[i]);
            chk(^cap[i] === 1'b1, "R1", $sformatf("parity char %0d", i), cap[i], exp_ch[i]);
        end
    endtask

    task automatic clear_in();
        for (int i = 0; i < 100; i++) begin
            in_dig[i] = 0; in_o[i] = 0; in_x[i] = 0;
        end
    endtask

    task automatic t_reset();
        chk(char_valid_o === 0 && done_o === 0 && busy_o === 0 && parity_err_o === 0,
            "R9", "reset state",
            {char_valid_o, done_o, busy_o, parity_err_o}, 0);
    endtask

    task automatic t_idle();
        done_n = 0; cap_n = 0;
        for (int i = 0; i < 4; i++) begin
            char_valid_i = 1; char_i = mkc(1, 0, i + 3);
            @(negedge clk);
        end
        char_valid_i = 0;
        repeat (2) @(negedge clk);
        chk(cap_n == 0 && done_n == 0 && busy_o === 0, "R9", "idle chars ignored",
            cap_n + done_n, 0);
    endtask

    task automatic t_pos();
        int v [5] = '{3, 0, 7, 1, 9};
        clear_in();
        for (int i = 0; i < 5; i++) begin
            in_dig[i] = v[i]; in_o[i] = i[0]; in_x[i] = (i > 0);
        end
        run_op(0, 0, 5, -1, "R2");
    endtask

    task automatic t_neg();
        int v [6] = '{0, 0, 5, 3, 0, 8};
        clear_in();
        for (int i = 0; i < 6; i++) begin in_dig[i] = v[i]; in_o[i] = (i == 3); end
        run_op(0, 1, 6, -1, "R3");
        clear_in();
        for (int i = 0; i < 7; i++) in_dig[i] = (i * 4 + 1) % 10;
        run_op(0, 1, 7, -1, "R3");
    endtask

    task automatic t_negzero();
        clear_in();
        in_o[1] = 1;
        run_op(0, 1, 4, -1, "R4");
    endtask

    task automatic t_tc();
        clear_in();
        for (int i = 0; i < 10; i++) begin
            in_dig[i] = (i * 7 + 2) % 10; in_x[i] = (i == 9); in_o[i] = (i == 5);
        end
        in_dig[0] = 0;
        run_op(1, 1, 10, -1, "R5");
        run_op(1, 0, 10, -1, "R5");
    endtask

    task automatic t_len();
        clear_in();
        in_dig[0] = 7;
        run_op(0, 1, 1, -1, "R6");
        clear_in();
        for (int i = 0; i < 100; i++) in_dig[i] = (i * 3 + 5) % 10;
        in_dig[0] = 0; in_dig[1] = 0;
        run_op(0, 1, 100, -1, "R6");
        run_op(1, 1, 100, -1, "R6");
    endtask

    task automatic t_parity();
        clear_in();
        for (int i = 0; i < 5; i++) in_dig[i] = i + 2;
        run_op(0, 1, 5, 2, "R7");
        chk(parity_err_o === 1'b1, "R7", "error flag set", parity_err_o, 1);
        repeat (3) @(negedge clk);
        chk(parity_err_o === 1'b1, "R7", "error flag held", parity_err_o, 1);
        run_op(0, 0, 5, -1, "R7");
        chk(parity_err_o === 1'b0, "R7", "flag cleared by start", parity_err_o, 0);
    endtask

    task automatic t_restart();
        clear_in();
        @(negedge clk);
        start_i = 1; len_i = 7'd5; dir_i = 0; acc_sign_i = 0;
        @(negedge clk);
        start_i = 0;
        for (int i = 0; i < 2; i++) begin
            char_valid_i = 1; char_i = mkc(i == 0, 0, 4);
            @(negedge clk);
        end
        char_valid_i = 0;
        @(negedge clk);
        chk(busy_o === 1'b1, "R10", "aborted op still busy", busy_o, 1);
        for (int i = 0; i < 3; i++) in_dig[i] = i + 6;
        run_op(0, 1, 3, -1, "R10");
        // start and a character in the same cycle: character dropped
        @(negedge clk);
        start_i = 1; len_i = 7'd1; dir_i = 0; acc_sign_i = 0;
        char_valid_i = 1; char_i = mkc(0, 0, 5);
        cap_n = 0; done_n = 0;
        @(negedge clk);
        start_i = 0; char_valid_i = 0;
        @(negedge clk);
        chk(cap_n == 0 && busy_o === 1'b1, "R10", "char with start ignored", cap_n, 0);
        char_valid_i = 1; char_i = mkc(0, 0, 2);
        @(negedge clk);
        char_valid_i = 0;
        repeat (3) @(negedge clk);
        chk(cap_n == 1 && cap[0] === mkc(0, 0, 2) && done_n == 1, "R10",
            "op after same-cycle start", cap[0], mkc(0, 0, 2));
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_pos();
        t_neg();
        t_negzero();
        t_tc();
        t_len();
        t_parity();
        t_restart();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule